// File: doc/BRIEF.md
# Triggered Sample History Capture with Block Readout

This block takes one digitized sample on every clock and writes it into a circular history. The history is deep enough that a trigger decision can arrive long after the samples it refers to. Writing never pauses. When a trigger is accepted, the block reaches back into the history by a programmed look-back distance. It then copies a programmed number of consecutive samples, one per clock, into an event buffer. A header word carrying an event number and the window length goes in front of them.

Completed events collect in the event buffer. Once the number of complete, undelivered events reaches the programmed block size, an interrupt is raised and the buffer opens to the readout side. The interrupt stays high until every word of that block has been taken through a valid/ready stream. A busy output shows when a new trigger cannot be served, either because a window copy is running or because the buffer has less room than one maximum-length event. Triggers that arrive while busy are dropped and counted.

Top module: `sample_history_capture`

## Requirements
- R1: A sample is written into the history on every clock after reset, including while busy. For an accepted trigger in cycle t with effective look-back L, the k-th sample word of the event equals the sample presented in cycle t-L+k. L is the look-back input, with values above HIST_DEPTH-1 (1999) treated as 1999, and 0 allowed.
- R2: The effective window length is 1 when win_len is 0, MAX_WIN (64) when win_len exceeds 64, and win_len otherwise. Exactly that many sample words follow each header.
- R3: A header word has rd_hdr=1, the event number in rd_data[15:0] and the effective window length in rd_data[22:16]. Event numbers start at 0 after reset, step by one per accepted trigger and wrap at 16 bits. A sample word has rd_hdr=0, the sample in rd_data[11:0] and zeros above.
- R4: busy is high during the W cycles that follow an accepted trigger while the window is copied (W = effective length). It is also high while the event buffer holds 1984 or more words, that is, less free room than one 65-word event.
- R5: A trigger in a cycle where busy is high writes nothing, leaves the event number unchanged, and increments drop_cnt by one (modulo 2^16).
- R6: Sampling has no deadtime. A window whose look-back reaches into the cycles in which an earlier window was being copied returns the samples presented in those cycles.
- R7: irq rises when the count of completed, undelivered events reaches the effective block size. While irq is high, rd_valid is high whenever the buffer holds a word, and rd_data shows the oldest word.
- R8: irq stays high until the last sample word of the block's last event is taken (rd_valid and rd_ready both high), and is low from the next cycle. rd_valid is never high while irq is low, and a word that is not taken stays on rd_data.
- R9: After reset, busy, irq, rd_valid and drop_cnt are all zero.
- R10: A block_size of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_in | input | SAMPLE_W (12) | Digitized sample for this cycle |
| trig | input | 1 | Trigger strobe, one cycle per trigger |
| lookback | input | $clog2(HIST_DEPTH) (11) | Distance back into the history, in samples |
| win_len | input | $clog2(MAX_WIN+1) (7) | Window length request, in samples |
| block_size | input | BLK_W (9) | Events per readout block |
| rd_ready | input | 1 | Readout side takes the current word |
| rd_valid | output | 1 | A word of the current block is on rd_data |
| rd_hdr | output | 1 | Current word is an event header |
| rd_data | output | WIN_W+EVNUM_W (23) | Header or sample word |
| busy | output | 1 | A trigger now would be dropped |
| irq | output | 1 | A block of events is ready or being drained |
| drop_cnt | output | EVNUM_W (16) | Number of dropped triggers, wrapping |

## Verification
Several corner cases get targeted stimulus. The look-back is pushed to the deepest history slot, where the copy reads the very entry being overwritten in that cycle; a design that read after the write would return samples one full history period too new. Triggers are held high through a whole copy to show that each one is dropped and counted; a design that queued them or lost the count would show extra headers or a low drop_cnt. The readout side stalls on alternate cycles, and a block is ended exactly on its last sample word, so an interrupt that fell early or a word lost during a stall would show at once. The event buffer is also filled to its room threshold with no readout, so that busy must come from buffer space rather than from a running copy.

// File: rtl/shc_pkg.sv
package shc_pkg;
    // Capture controller state: idle, or copying a window out of the history
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_COPY = 1'b1
    } cap_state_t;
endpackage

// File: rtl/shc_history_ring.sv
// Circular sample history.
// Writes samp_in at the write pointer on every clock, with no deadtime.
// On load the read pointer is set to (write pointer - look-back) modulo DEPTH.
// On advance it steps forward by one. The read is asynchronous, so a read of
// the slot being written in the same cycle returns the older sample.
// Assumes load and advance are never high together.
module shc_history_ring #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      samp_in,
    input  logic [$clog2(DEPTH)-1:0] lookback,
    input  logic                     load,
    input  logic                     advance,
    output logic [SAMPLE_W-1:0]      rd_sample
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [AW:0]   DEPTH_X = (AW+1)'(DEPTH);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW-1:0] lb_eff;
    logic [AW-1:0] start_addr;

    // Clamp the look-back to the deepest slot the history can hold
    always_comb lb_eff = (lookback > LAST) ? LAST : lookback;

    // Start address of a window, wrapped modulo DEPTH
    always_comb begin
        if (wp >= lb_eff) start_addr = wp - lb_eff;
        else              start_addr = AW'(({1'b0, wp} + DEPTH_X) - {1'b0, lb_eff});
    end

    // Store the incoming sample every cycle
    always_ff @(posedge clk) mem[wp] <= samp_in;

    // Write pointer walks the ring continuously
    always_ff @(posedge clk) begin
        if (!rst_n)          wp <= '0;
        else if (wp == LAST) wp <= '0;
        else                 wp <= wp + AW'(1);
    end

    // Read pointer: loaded on trigger, stepped while copying
    always_ff @(posedge clk) begin
        if (!rst_n)       rp <= '0;
        else if (load)    rp <= start_addr;
        else if (advance) rp <= (rp == LAST) ? '0 : rp + AW'(1);
    end

    assign rd_sample = mem[rp];

    // R1: both pointers stay inside the ring
    a_r1_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wp <= LAST) && (rp <= LAST));
    // R1: each advance moves the read pointer by exactly one slot
    a_r1_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (rp == (($past(rp) == LAST) ? '0 : $past(rp) + AW'(1))));
endmodule

// File: rtl/shc_capture_ctrl.sv
// Trigger acceptance and window copy.
// A trigger is accepted when not busy. That cycle emits a header word
// {1, len, evnum}. The next len cycles emit one zero-extended sample word
// each. Triggers seen while busy are dropped and counted.
// Assumes near_full is raised while the buffer has room for less than one
// maximum-length event.
module shc_capture_ctrl
    import shc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int MAX_WIN  = 64,
    parameter int EVNUM_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             trig,
    input  logic [$clog2(MAX_WIN+1)-1:0]     win_len,
    input  logic                             near_full,
    input  logic [SAMPLE_W-1:0]              sample,
    output logic                             busy,
    output logic                             load,
    output logic                             advance,
    output logic                             push,
    output logic [$clog2(MAX_WIN+1)+EVNUM_W:0] push_word,
    output logic                             ev_done,
    output logic [EVNUM_W-1:0]               drop_cnt
);
    localparam int WIN_W  = $clog2(MAX_WIN+1);
    localparam int WORD_W = 1 + WIN_W + EVNUM_W;
    localparam logic [WIN_W-1:0] WMAX = WIN_W'(MAX_WIN);

    cap_state_t         state;
    logic [WIN_W-1:0]   rem;
    logic [WIN_W-1:0]   win_eff;
    logic [EVNUM_W-1:0] evnum;
    logic               accept;

    // Map the requested window length into 1..MAX_WIN
    always_comb begin
        if (win_len == '0)       win_eff = WIN_W'(1);
        else if (win_len > WMAX) win_eff = WMAX;
        else                     win_eff = win_len;
    end

    assign busy      = (state == CAP_COPY) || near_full;
    assign accept    = trig && !busy;
    assign load      = accept;
    assign advance   = (state == CAP_COPY);
    assign push      = accept || (state == CAP_COPY);
    assign push_word = accept ? {1'b1, win_eff, evnum} : WORD_W'(sample);
    assign ev_done   = (state == CAP_COPY) && (rem == WIN_W'(1));

    // Copy sequencer: start on accept, finish after the last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            rem   <= '0;
        end else if (accept) begin
            state <= CAP_COPY;
            rem   <= win_eff;
        end else if (state == CAP_COPY) begin
            rem <= rem - WIN_W'(1);
            if (rem == WIN_W'(1)) state <= CAP_IDLE;
        end
    end

    // Event numbering: one step per accepted trigger
    always_ff @(posedge clk) begin
        if (!rst_n)      evnum <= '0;
        else if (accept) evnum <= evnum + EVNUM_W'(1);
    end

    // Dropped-trigger tally
    always_ff @(posedge clk) begin
        if (!rst_n)           drop_cnt <= '0;
        else if (trig && busy) drop_cnt <= drop_cnt + EVNUM_W'(1);
    end

    // R5: a trigger while busy bumps the drop count and leaves evnum alone
    a_r5_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> (drop_cnt == $past(drop_cnt) + EVNUM_W'(1)) && (evnum == $past(evnum)));
    // R3: accepted trigger advances the event number by one
    a_r3_evnum_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (evnum == $past(evnum) + EVNUM_W'(1)));
    // R4: busy holds through the copy that follows an accept
    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: rtl/shc_event_fifo.sv
// Event buffer: single-clock FIFO with asynchronous read of the head word.
// Assumes DEPTH is a power of two. Raises near_full when fewer than SLACK
// free slots remain.
module shc_event_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 2048,
    parameter int SLACK = 65
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         near_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH - SLACK + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;

    // Store pushed words
    always_ff @(posedge clk) if (wr_en) mem[wptr] <= wr_data;

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= wptr + AW'(1);
            if (rd_en) rptr <= rptr + AW'(1);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign head      = mem[rptr];
    assign empty     = (count == '0);
    assign near_full = (count >= FULL_AT);

    // R4: the busy threshold keeps every push inside the buffer
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count != CW'(DEPTH)));
    // R8: the readout side never pops an empty buffer
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/shc_block_gate.sv
// Block interrupt and readout gate.
// Counts completed events. When the count reaches the block size, it raises
// irq and opens the stream. It follows header lengths to find the last word
// of the block, and drops irq after that word is taken.
// Assumes headers carry a length of at least 1 and that the event buffer can
// hold a whole block.
module shc_block_gate #(
    parameter int BLK_W  = 9,
    parameter int WIN_W  = 7,
    parameter int PEND_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic [BLK_W-1:0] block_size,
    input  logic             fifo_empty,
    input  logic             head_is_hdr,
    input  logic [WIN_W-1:0] head_len,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic             pop,
    output logic             irq
);
    logic [BLK_W-1:0]  bs_eff;
    logic [PEND_W-1:0] pend;
    logic [BLK_W-1:0]  ev_left;
    logic [WIN_W-1:0]  words_left;
    logic              raise;

    assign bs_eff   = (block_size == '0) ? BLK_W'(1) : block_size;
    assign raise    = !irq && (pend >= PEND_W'(bs_eff));
    assign rd_valid = irq && !fifo_empty;
    assign pop      = rd_valid && rd_ready;

    // Completed events not yet handed to a block
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else pend <= pend - (raise ? PEND_W'(bs_eff) : '0) + PEND_W'(ev_done);
    end

    // Interrupt and drain tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            ev_left    <= '0;
            words_left <= '0;
        end else if (raise) begin
            irq     <= 1'b1;
            ev_left <= bs_eff;
        end else if (pop) begin
            if (head_is_hdr) begin
                words_left <= head_len;
            end else begin
                words_left <= words_left - WIN_W'(1);
                if (words_left == WIN_W'(1)) begin
                    ev_left <= ev_left - BLK_W'(1);
                    if (ev_left == BLK_W'(1)) irq <= 1'b0;
                end
            end
        end
    end

    // R8: stream is only open while the block interrupt is up
    a_r8_valid_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> irq);
    // R8: irq only falls right after a word was taken
    a_r8_irq_falls_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(pop));
    // R8: a stalled word stays put
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid);
endmodule

// File: rtl/sample_history_capture.sv
// Top level: sample history, trigger-driven window capture, event buffer and
// per-block readout interrupt. Output word = {len, evnum} for headers, or a
// zero-extended sample. rd_hdr marks headers.
// Assumes block_size*(window+1) fits in the event buffer below its busy threshold.
module sample_history_capture #(
    parameter int SAMPLE_W   = 12,
    parameter int HIST_DEPTH = 2000,
    parameter int MAX_WIN    = 64,
    parameter int EVB_DEPTH  = 2048,
    parameter int EVNUM_W    = 16,
    parameter int BLK_W      = 9
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SAMPLE_W-1:0]                  samp_in,
    input  logic                                 trig,
    input  logic [$clog2(HIST_DEPTH)-1:0]        lookback,
    input  logic [$clog2(MAX_WIN+1)-1:0]         win_len,
    input  logic [BLK_W-1:0]                     block_size,
    input  logic                                 rd_ready,
    output logic                                 rd_valid,
    output logic                                 rd_hdr,
    output logic [$clog2(MAX_WIN+1)+EVNUM_W-1:0] rd_data,
    output logic                                 busy,
    output logic                                 irq,
    output logic [EVNUM_W-1:0]                   drop_cnt
);
    localparam int WIN_W  = $clog2(MAX_WIN+1);
    localparam int WORD_W = 1 + WIN_W + EVNUM_W;
    localparam int PEND_W = $clog2(EVB_DEPTH+1);

    logic [SAMPLE_W-1:0] hist_sample;
    logic                load;
    logic                advance;
    logic                push;
    logic [WORD_W-1:0]   push_word;
    logic                ev_done;
    logic                near_full;
    logic                fifo_empty;
    logic [WORD_W-1:0]   head;
    logic                pop;

    shc_history_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(HIST_DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .lookback(lookback),
        .load(load), .advance(advance), .rd_sample(hist_sample));

    shc_capture_ctrl #(.SAMPLE_W(SAMPLE_W), .MAX_WIN(MAX_WIN), .EVNUM_W(EVNUM_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .trig(trig), .win_len(win_len),
        .near_full(near_full), .sample(hist_sample), .busy(busy),
        .load(load), .advance(advance), .push(push), .push_word(push_word),
        .ev_done(ev_done), .drop_cnt(drop_cnt));

    shc_event_fifo #(.W(WORD_W), .DEPTH(EVB_DEPTH), .SLACK(MAX_WIN+1)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_word),
        .rd_en(pop), .head(head), .empty(fifo_empty), .near_full(near_full));

    shc_block_gate #(.BLK_W(BLK_W), .WIN_W(WIN_W), .PEND_W(PEND_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .block_size(block_size),
        .fifo_empty(fifo_empty), .head_is_hdr(head[WORD_W-1]),
        .head_len(head[WORD_W-2 -: WIN_W]), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .pop(pop), .irq(irq));

    assign rd_hdr  = head[WORD_W-1];
    assign rd_data = head[WORD_W-2:0];
endmodule

// File: tb/tb_sample_history_capture.sv
module tb_sample_history_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] samp_in = '0;
    logic        trig = 1'b0;
    logic [10:0] lookback = 11'd10;
    logic [6:0]  win_len = 7'd4;
    logic [8:0]  block_size = 9'd2;
    logic        rd_ready = 1'b1;
    logic        rd_valid, rd_hdr, busy, irq;
    logic [22:0] rd_data;
    logic [15:0] drop_cnt;

    sample_history_capture dut (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .trig(trig),
        .lookback(lookback), .win_len(win_len), .block_size(block_size),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_hdr(rd_hdr),
        .rd_data(rd_data), .busy(busy), .irq(irq), .drop_cnt(drop_cnt));

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    string data_tag = "R1";
    string irq_tag = "R7";

    // Reference model state
    int          hist[$];
    logic [23:0] mq[$];
    bit          m_cap = 0;
    bit          m_irq = 0;
    int          m_rcyc, m_rem, m_evnum = 0, m_drop = 0, m_done = 0, m_evleft = 0, m_wleft = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_busy();
        return m_cap || (mq.size() >= 1984);
    endfunction

    function automatic int weff(input int w);
        return (w == 0) ? 1 : ((w > 64) ? 64 : w);
    endfunction

    // Advance the model by one clock, using the inputs held at that edge
    task automatic model_update();
        bit busy_pre = m_busy();
        bit irq_pre = m_irq;
        int done_pre = m_done;
        bit cap_pre = m_cap;
        int bs_eff = (block_size == 0) ? 1 : int'(block_size);
        int lb_eff = (lookback > 1999) ? 1999 : int'(lookback);
        bit fin = 0;
        logic [23:0] w;
        if (irq_pre && mq.size() > 0 && rd_ready) begin
            w = mq.pop_front();
            if (w[23]) m_wleft = int'(w[22:16]);
            else begin
                if (m_wleft == 1) begin
                    m_evleft--;
                    if (m_evleft == 0) m_irq = 0;
                end
                m_wleft--;
            end
        end
        if (cap_pre) begin
            mq.push_back({12'h000, 12'(hist[m_rcyc])});
            m_rcyc++;
            m_rem--;
            if (m_rem == 0) begin m_cap = 0; fin = 1; end
        end
        if (trig) begin
            if (busy_pre) m_drop++;
            else begin
                mq.push_back({1'b1, 7'(weff(int'(win_len))), 16'(m_evnum)});
                m_evnum = (m_evnum + 1) & 16'hFFFF;
                m_cap = 1;
                m_rcyc = hist.size() - lb_eff;
                m_rem = weff(int'(win_len));
            end
        end
        if (!irq_pre && done_pre >= bs_eff) begin
            m_irq = 1;
            m_evleft = bs_eff;
            m_done -= bs_eff;
        end
        if (fin) m_done++;
        hist.push_back(int'(samp_in));
    endtask

    // Compare every output against the model
    task automatic compare();
        bit exp_valid = m_irq && (mq.size() > 0);
        chk(busy == m_busy(), "R4", "busy", int'(busy), int'(m_busy()));
        chk(drop_cnt == 16'(m_drop), "R5", "drop_cnt", int'(drop_cnt), m_drop & 16'hFFFF);
        chk(irq == m_irq, irq_tag, "irq", int'(irq), int'(m_irq));
        chk(rd_valid == exp_valid, "R8", "rd_valid", int'(rd_valid), int'(exp_valid));
        if (exp_valid && rd_valid) begin
            chk(rd_hdr == mq[0][23], "R2", "rd_hdr", int'(rd_hdr), int'(mq[0][23]));
            if (mq[0][23]) chk(rd_data == mq[0][22:0], "R3", "header", int'(rd_data), int'(mq[0][22:0]));
            else           chk(rd_data == mq[0][22:0], data_tag, "sample", int'(rd_data), int'(mq[0][22:0]));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
        if (rst_n) compare();
        samp_in = 12'($urandom);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic fire();
        trig = 1'b1;
        tick();
        trig = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        run_reset: begin
            repeat (3) @(negedge clk);
            // R9: reset values
            chk(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
            chk(irq == 1'b0, "R9", "irq in reset", int'(irq), 0);
            chk(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
            chk(drop_cnt == 16'd0, "R9", "drop_cnt in reset", int'(drop_cnt), 0);
            rst_n = 1'b1;
        end
        // Fill the whole history before any deep look-back
        run(2100);
        // Basic two-event block (R1, R3, R7)
        fire(); run(10); fire(); run(20);
        // Trigger held high: copies plus drops (R4, R5)
        trig = 1'b1; run(12); trig = 1'b0; run(40);
        // Back-pressure during a three-event block (R8)
        block_size = 9'd3;
        fire(); run(8); fire(); run(8); fire();
        for (int i = 0; i < 60; i++) begin rd_ready = i[0]; tick(); end
        rd_ready = 1'b1; run(20);
        // Look-back extremes: deepest slot, clamped value, zero (R1)
        lookback = 11'd1999; fire(); run(6);
        lookback = 11'd2047; fire(); run(6);
        lookback = 11'd0;    fire(); run(30);
        // Look-back reaching into a previous copy (R6)
        data_tag = "R6"; block_size = 9'd2;
        lookback = 11'd20; win_len = 7'd16;
        fire(); run(16); fire(); run(60);
        data_tag = "R1";
        // Window length mapping (R2)
        win_len = 7'd0; fire(); run(3);
        win_len = 7'd100; fire(); run(70);
        win_len = 7'd64; run(150);
        // Block size zero acts as one (R10)
        irq_tag = "R10"; block_size = 9'd0; win_len = 7'd3;
        fire(); run(10); fire(); run(10);
        irq_tag = "R7";
        // Fill the buffer to its room threshold with readout stalled (R4)
        rd_ready = 1'b0; block_size = 9'd40; win_len = 7'd64; lookback = 11'd100;
        for (int i = 0; i < 33; i++) begin fire(); run(66); end
        block_size = 9'd30; rd_ready = 1'b1; run(2100);
        block_size = 9'd1; run(100);
        finish_run();
    end
endmodule